// File: doc/BRIEF.md
# Vector Length and Element Step Controller

This unit keeps the loop state of a vector engine: the maximum vector length, the active vector length, and one element index each for the source and the destination side. It decodes a length-control operation. That operation carries three mode bits (`opVf`, `opVs`, `opMs`), a record flag, an immediate, and a register operand that is either a value or the zero register. From these the unit does one of three things. It loads the lengths and returns the resulting active length for a destination register. It reports the active length without changing any state. Or, in vertical-first step mode, it moves both element indices on to the next element that their predicate masks enable.

A step operation that has the record flag set also produces a 4-bit condition field. The field shows whether either index has reached the active length. The immediate can also select one of four loop-state records, and the inner, middle and outer loop-end flags of that record are copied into the field. The remap schedule generators outside this unit supply those flags. Ordinary vector instructions never move the indices, so a branch loop drives progress through explicit step operations.

Top module: `vlen_step_unit`

## Requirements
- R1: A synchronous reset sets the maximum length and the active length to 1, sets both element indices to 0, and drives `rdWe`, `crWe` and `crVal` to 0.
- R2: An operation with `opVf`=0 and `opMs`=1 loads the maximum length. The value used is the immediate when `srcIsZero`=1 and `srcVal` otherwise. A value of 0 becomes 1, and a value above MAX_VL becomes MAX_VL.
- R3: When `opVf`=0 and `opVs`=1, the active length is loaded from the same value, capped at the maximum length that results from the same operation. If both `opMs` and `opVs` are set, both lengths come from that one value. Whenever the maximum length drops below the active length, the active length is capped to it.
- R4: Every operation with `opVf`=0 pulses `rdWe` for one cycle, with `rdVal` equal to the resulting active length. With `opVs`=`opMs`=0 no length and no index changes.
- R5: A step operation (`opVf`=1, `opVs`=0, `opMs`=0) moves each index to the lowest position above its current value and below the active length whose mask bit is 1 (`srcMask` for the source index, `dstMask` for the destination index). If there is no such position, the index saturates at the active length and never wraps.
- R6: The element indices change only on step operations. An operation with `opVf`=1 and either `opVs` or `opMs` set changes no state and produces no output pulse.
- R7: A step with `opRc`=1 pulses `crWe`. Bit 0 of `crVal` (the summary-overflow position) is 1 exactly when either index equals the active length after the step. With immediate 1 the other three bits are 0.
- R8: With immediates 2, 3, 4 and 5, loop-state record 0, 1, 2 and 3 respectively is reported. The record's inner flag goes to `crVal[1]` (EQ), its middle flag to `crVal[3]` (LT) and its outer flag to `crVal[2]` (GT). Record k occupies `loopEnd[3k]` (inner), `loopEnd[3k+1]` (middle) and `loopEnd[3k+2]` (outer).
- R9: With `opRc`=0, `crWe` stays 0 and `crVal` keeps its value. With `opRc`=1 and an immediate outside 1..5, `crVal` is written as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opVf | input | 1 | Vertical-first mode bit |
| opVs | input | 1 | Set-active-length bit |
| opMs | input | 1 | Set-maximum-length bit |
| opRc | input | 1 | Record condition field |
| srcIsZero | input | 1 | Register operand is the zero register; use the immediate |
| srcVal | input | DATA_W | Register operand value |
| opImm | input | IMM_W | Immediate |
| srcMask | input | MAX_VL | Source predicate mask |
| dstMask | input | MAX_VL | Destination predicate mask |
| loopEnd | input | 12 | Inner/middle/outer end flags of four loop-state records |
| mvlOut | output | IDX_W | Maximum vector length |
| vlOut | output | IDX_W | Active vector length |
| srcStep | output | IDX_W | Source element index |
| dstStep | output | IDX_W | Destination element index |
| rdWe | output | 1 | Destination register write strobe |
| rdVal | output | DATA_W | Value for the destination register |
| crWe | output | 1 | Condition field write strobe |
| crVal | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Every result of an operation presented before a rising edge becomes visible after that edge. The lengths, the indices, `rdWe`/`rdVal` and `crWe`/`crVal` all arrive one cycle after the stimulus, and the strobes fall again one cycle later. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares every output on the next falling edge, so each comparison lands exactly one register stage after the operation. Directed checks cover mask skipping, saturation at the active length, every immediate selector and ignored mode combinations. A random phase then mixes all operation kinds.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  // Strobes sent from the decoder to the datapath.
  typedef struct packed {
    logic       ldMvl;   // load maximum length
    logic       ldVl;    // load active length
    logic       rdEn;    // return active length
    logic       step;    // advance element indices
    logic       crEn;    // write the condition field
    logic [2:0] crMode;  // 0: zero field, 1: length test only, 2..5: record 0..3
  } vlStrobe_t;

  localparam int CR_W  = 4;
  localparam int END_W = 3;
  localparam int NREC  = 4;

endpackage

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
#(
  parameter int IMM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic             opVf,
  input  logic             opVs,
  input  logic             opMs,
  input  logic             opRc,
  input  logic [IMM_W-1:0] opImm,
  output vlStrobe_t        strb
);

  logic stepForm;
  logic immInRange;

  assign stepForm   = opVf && !opVs && !opMs;
  assign immInRange = (opImm >= IMM_W'(1)) && (opImm <= IMM_W'(5));

  always_comb begin
    strb = '0;
    if (opValid) begin
      if (!opVf) begin
        strb.rdEn  = 1'b1;
        strb.ldMvl = opMs;
        strb.ldVl  = opVs;
      end else if (stepForm) begin
        strb.step   = 1'b1;
        strb.crEn   = opRc;
        strb.crMode = immInRange ? opImm[2:0] : 3'd0;
      end
    end
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.step, strb.rdEn}));

endmodule

// File: rtl/vlen_skip.sv
module vlen_skip #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 7
) (
  input  logic [IDX_W-1:0]  cur,
  input  logic [IDX_W-1:0]  lim,
  input  logic [MAX_VL-1:0] mask,
  output logic [IDX_W-1:0]  nxt
);

  // Lowest enabled position strictly above cur and below lim; lim if none.
  always_comb begin
    nxt = lim;
    for (int j = MAX_VL - 1; j >= 0; j--) begin
      if (j > int'(cur) && j < int'(lim) && mask[j]) nxt = IDX_W'(j);
    end
  end

endmodule

// File: rtl/vlen_dp.sv
module vlen_dp
  import vlen_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MAX_VL = 64,
  parameter int IMM_W  = 7,
  parameter int IDX_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  vlStrobe_t             strb,
  input  logic                  srcIsZero,
  input  logic [DATA_W-1:0]     srcVal,
  input  logic [IMM_W-1:0]      opImm,
  input  logic [MAX_VL-1:0]     srcMask,
  input  logic [MAX_VL-1:0]     dstMask,
  input  logic [NREC*END_W-1:0] loopEnd,
  output logic [IDX_W-1:0]      mvl,
  output logic [IDX_W-1:0]      vl,
  output logic [IDX_W-1:0]      srcStep,
  output logic [IDX_W-1:0]      dstStep,
  output logic                  rdWe,
  output logic [DATA_W-1:0]     rdVal,
  output logic                  crWe,
  output logic [CR_W-1:0]       crVal
);

  localparam logic [IDX_W-1:0] MaxLen = IDX_W'(MAX_VL);

  logic [DATA_W-1:0]    opValue;
  logic [IDX_W-1:0]     mvlNext, vlNext;
  logic [IDX_W-1:0]     curIdx [2];
  logic [IDX_W-1:0]     nxtIdx [2];
  logic [MAX_VL-1:0]    maskSel[2];
  logic                 reachedVl;
  logic [END_W-1:0]     recFlags;
  logic [CR_W-1:0]      crNext;

  assign opValue = srcIsZero ? DATA_W'(opImm) : srcVal;

  always_comb begin
    mvlNext = mvl;
    if (strb.ldMvl) begin
      if (opValue == '0)                      mvlNext = IDX_W'(1);
      else if (opValue > DATA_W'(MAX_VL))     mvlNext = MaxLen;
      else                                    mvlNext = opValue[IDX_W-1:0];
    end
    if (strb.ldVl)
      vlNext = (opValue > DATA_W'(mvlNext)) ? mvlNext : opValue[IDX_W-1:0];
    else
      vlNext = (vl > mvlNext) ? mvlNext : vl;
  end

  assign curIdx[0]  = srcStep;
  assign curIdx[1]  = dstStep;
  assign maskSel[0] = srcMask;
  assign maskSel[1] = dstMask;

  for (genvar g = 0; g < 2; g++) begin : g_skip
    vlen_skip #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_skip (
      .cur (curIdx[g]),
      .lim (vl),
      .mask(maskSel[g]),
      .nxt (nxtIdx[g])
    );
  end

  assign reachedVl = (nxtIdx[0] == vl) || (nxtIdx[1] == vl);

  always_comb begin
    case (strb.crMode)
      3'd2:    recFlags = loopEnd[0*END_W +: END_W];
      3'd3:    recFlags = loopEnd[1*END_W +: END_W];
      3'd4:    recFlags = loopEnd[2*END_W +: END_W];
      3'd5:    recFlags = loopEnd[3*END_W +: END_W];
      default: recFlags = '0;
    endcase
    case (strb.crMode)
      3'd1:                crNext = {3'b000, reachedVl};
      3'd2, 3'd3, 3'd4, 3'd5:
                           crNext = {recFlags[1], recFlags[2], recFlags[0], reachedVl};
      default:             crNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mvl     <= IDX_W'(1);
      vl      <= IDX_W'(1);
      srcStep <= '0;
      dstStep <= '0;
      rdWe    <= 1'b0;
      rdVal   <= '0;
      crWe    <= 1'b0;
      crVal   <= '0;
    end else begin
      mvl  <= mvlNext;
      vl   <= vlNext;
      rdWe <= strb.rdEn;
      crWe <= strb.crEn;
      if (strb.rdEn) rdVal <= DATA_W'(vlNext);
      if (strb.step) begin
        srcStep <= nxtIdx[0];
        dstStep <= nxtIdx[1];
      end
      if (strb.crEn) crVal <= crNext;
    end
  end

  // R2
  mvl_range_chk: assert property (@(posedge clk) disable iff (rst)
    mvl >= IDX_W'(1) && mvl <= MaxLen);

  // R3
  vl_cap_chk: assert property (@(posedge clk) disable iff (rst) vl <= mvl);

  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && !strb.ldVl && !strb.ldMvl) |=> ($stable(vl) && $stable(mvl)));

  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.step |=> ($stable(srcStep) && $stable(dstStep)));

  // R5
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strb.step |=> (srcStep <= vl && dstStep <= vl));

endmodule

// File: rtl/vlen_step_unit.sv
module vlen_step_unit
  import vlen_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MAX_VL = 64,
  parameter int IMM_W  = 7,
  localparam int IDX_W = $clog2(MAX_VL + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  opValid,
  input  logic                  opVf,
  input  logic                  opVs,
  input  logic                  opMs,
  input  logic                  opRc,
  input  logic                  srcIsZero,
  input  logic [DATA_W-1:0]     srcVal,
  input  logic [IMM_W-1:0]      opImm,
  input  logic [MAX_VL-1:0]     srcMask,
  input  logic [MAX_VL-1:0]     dstMask,
  input  logic [NREC*END_W-1:0] loopEnd,
  output logic [IDX_W-1:0]      mvlOut,
  output logic [IDX_W-1:0]      vlOut,
  output logic [IDX_W-1:0]      srcStep,
  output logic [IDX_W-1:0]      dstStep,
  output logic                  rdWe,
  output logic [DATA_W-1:0]     rdVal,
  output logic                  crWe,
  output logic [CR_W-1:0]       crVal
);

  vlStrobe_t strb;

  vlen_ctrl #(.IMM_W(IMM_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opValid(opValid),
    .opVf   (opVf),
    .opVs   (opVs),
    .opMs   (opMs),
    .opRc   (opRc),
    .opImm  (opImm),
    .strb   (strb)
  );

  vlen_dp #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .srcIsZero(srcIsZero),
    .srcVal   (srcVal),
    .opImm    (opImm),
    .srcMask  (srcMask),
    .dstMask  (dstMask),
    .loopEnd  (loopEnd),
    .mvl      (mvlOut),
    .vl       (vlOut),
    .srcStep  (srcStep),
    .dstStep  (dstStep),
    .rdWe     (rdWe),
    .rdVal    (rdVal),
    .crWe     (crWe),
    .crVal    (crVal)
  );

  // R9
  no_rc_cr_chk: assert property (@(posedge clk) disable iff (rst)
    (!opValid || !opRc) |=> !crWe);

endmodule

// File: tb/vlen_step_unit_tb.sv
module vlen_step_unit_tb;

  localparam int DATA_W = 64;
  localparam int MAX_VL = 64;
  localparam int IMM_W  = 7;
  localparam int IDX_W  = $clog2(MAX_VL + 1);

  logic              clk = 1'b0;
  logic              rst;
  logic              opValid, opVf, opVs, opMs, opRc, srcIsZero;
  logic [DATA_W-1:0] srcVal;
  logic [IMM_W-1:0]  opImm;
  logic [MAX_VL-1:0] srcMask, dstMask;
  logic [11:0]       loopEnd;
  logic [IDX_W-1:0]  mvlOut, vlOut, srcStep, dstStep;
  logic              rdWe, crWe;
  logic [DATA_W-1:0] rdVal;
  logic [3:0]        crVal;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit modelOn = 1'b0;

  // behavioural reference state
  int          mMvl = 1, mVl = 1, mSrc = 0, mDst = 0, mCr = 0;
  bit          mRdWe = 0, mCrWe = 0;
  longint unsigned mRd = 0;

  always #2 clk = ~clk;  // 250 MHz

  vlen_step_unit #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .IMM_W(IMM_W)) u_dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opVf(opVf), .opVs(opVs), .opMs(opMs),
    .opRc(opRc), .srcIsZero(srcIsZero), .srcVal(srcVal), .opImm(opImm),
    .srcMask(srcMask), .dstMask(dstMask), .loopEnd(loopEnd),
    .mvlOut(mvlOut), .vlOut(vlOut), .srcStep(srcStep), .dstStep(dstStep),
    .rdWe(rdWe), .rdVal(rdVal), .crWe(crWe), .crVal(crVal)
  );

  function automatic int nextPos(int cur, logic [MAX_VL-1:0] m, int lim);
    for (int j = cur + 1; j < lim; j++) if (m[j]) return j;
    return lim;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mMvl = 1; mVl = 1; mSrc = 0; mDst = 0; mCr = 0; mRdWe = 0; mCrWe = 0; mRd = 0;
    end else begin
      longint unsigned v;
      v = srcIsZero ? longint'(opImm) : srcVal;
      mRdWe = 0; mCrWe = 0;
      if (opValid && !opVf) begin
        if (opMs) mMvl = (v == 0) ? 1 : (v > MAX_VL) ? MAX_VL : int'(v);
        if (opVs) mVl = (v > longint'(mMvl)) ? mMvl : int'(v);
        if (mVl > mMvl) mVl = mMvl;
        mRdWe = 1; mRd = longint'(mVl);
      end else if (opValid && opVf && !opVs && !opMs) begin
        int ns, nd, so, sel;
        ns = nextPos(mSrc, srcMask, mVl);
        nd = nextPos(mDst, dstMask, mVl);
        so = (ns == mVl || nd == mVl) ? 1 : 0;
        if (opRc) begin
          mCrWe = 1;
          sel = int'(opImm);
          if (sel == 1) mCr = so;
          else if (sel >= 2 && sel <= 5) begin
            int b;
            b = (sel - 2) * 3;
            mCr = so + (int'(loopEnd[b]) << 1) + (int'(loopEnd[b+2]) << 2)
                     + (int'(loopEnd[b+1]) << 3);
          end else mCr = 0;
        end
        mSrc = ns; mDst = nd;
      end
    end
  end

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (modelOn) begin
      chk("R2 mvl", longint'(mvlOut), longint'(mMvl));
      chk("R3 vl", longint'(vlOut), longint'(mVl));
      chk("R4 rdWe", longint'(rdWe), longint'(mRdWe));
      if (mRdWe) chk("R4 rdVal", rdVal, mRd);
      chk("R5 R6 srcStep", longint'(srcStep), longint'(mSrc));
      chk("R5 R6 dstStep", longint'(dstStep), longint'(mDst));
      chk("R7 R9 crWe", longint'(crWe), longint'(mCrWe));
      chk("R7 crVal.SO", longint'(crVal[0]), longint'(mCr & 1));
      chk("R8 R9 crVal", longint'(crVal), longint'(mCr));
    end
    if (cycles > 100000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic op(bit vf, bit vs, bit ms, bit rc, bit z, longint unsigned sv, int imm);
    @(negedge clk);
    opValid = 1; opVf = vf; opVs = vs; opMs = ms; opRc = rc;
    srcIsZero = z; srcVal = sv; opImm = IMM_W'(imm);
    @(negedge clk);
    opValid = 0;
  endtask

  initial begin
    rst = 1; opValid = 0; opVf = 0; opVs = 0; opMs = 0; opRc = 0; srcIsZero = 1;
    srcVal = '0; opImm = '0; srcMask = '1; dstMask = '1; loopEnd = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mvl", longint'(mvlOut), 1);
    chk("R1 vl", longint'(vlOut), 1);
    chk("R1 steps", longint'({srcStep, dstStep}), 0);
    chk("R1 strobes", longint'({rdWe, crWe, crVal}), 0);
    modelOn = 1;

    op(0, 1, 1, 0, 1, 0, 8);           // R2 R3 both lengths from one immediate
    op(0, 0, 0, 0, 1, 0, 0);           // R4 read form
    srcMask = 64'h0000_0000_0000_00A5; // enabled 0,2,5,7
    dstMask = 64'h0000_0000_0000_0012; // enabled 1,4
    loopEnd = 12'b101_010_110_001;
    op(1, 0, 0, 1, 1, 0, 1);           // R5 R7
    op(1, 0, 0, 1, 1, 0, 2);           // R8 record 0
    op(1, 0, 0, 1, 1, 0, 3);           // R8 record 1, dst saturates
    op(1, 1, 0, 1, 1, 0, 4);           // R6 ignored
    op(1, 0, 1, 0, 1, 0, 4);           // R6 ignored
    op(1, 0, 0, 1, 1, 0, 4);           // R8 record 2
    op(1, 0, 0, 1, 1, 0, 5);           // R8 record 3, saturation
    op(1, 0, 0, 0, 1, 0, 5);           // R9 rc off
    op(1, 0, 0, 1, 1, 0, 0);           // R9 undefined selector
    op(0, 0, 1, 0, 1, 0, 100);         // R2 clamp high
    op(0, 0, 1, 0, 0, 3, 0);           // R2 register source, R3 vl capped
    op(0, 0, 1, 0, 1, 0, 0);           // R2 zero becomes 1
    op(0, 1, 0, 0, 0, 64'hFFFF_0000_0000_0000, 0); // R3 capped
    op(0, 1, 1, 0, 0, 40, 0);
    op(0, 1, 0, 0, 1, 0, 0);           // vl 0
    op(1, 0, 0, 1, 1, 0, 1);           // R7 so with empty length

    for (int i = 0; i < 2000; i++) begin
      srcMask = {$urandom, $urandom};
      dstMask = {$urandom, $urandom};
      loopEnd = 12'($urandom);
      op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         ($urandom % 4 == 0) ? {$urandom, $urandom} : longint'($urandom % 70),
         ($urandom % 3 == 0) ? int'($urandom % 128) : int'($urandom % 8));
      if (i % 500 == 499) begin
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
      end
    end
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule